// File: doc/BRIEF.md
# Memory-Mapped SPI Host Controller

This block lets a processor run complete SPI byte exchanges without toggling the serial lines from software. The processor sees three 32-bit words on a simple word-addressed register port. One is a status word with a finished flag and a busy flag. One is a control word that holds a start bit, the level of the chip-select pin and a 30-bit serial-clock divider. The third is a data word: writing it loads the byte to send, and reading it returns the byte received in the last exchange.

Once started, an internal state machine shifts eight bits out on the serial data output and eight bits in from the serial data input, most significant bit first. It uses SPI mode 0: the serial clock idles low, the input is sampled on each rising clock edge and the output changes on each falling edge. The serial clock comes from the system clock through the programmable divider. The chip-select pin is a plain output whose level software sets through the control word. The block does not drive it during an exchange.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0 (divider 0, chip select low), the data word reads 0, and the serial clock, serial data output and chip-select pins are all low.
- R2: Status bit 1 (busy) reads 1 from the cycle after a start is accepted until the exchange ends. Status bit 0 (finished) is set in the cycle busy clears, stays set until the next start is accepted, and clears when that start is accepted.
- R3: A start request written while busy is ignored. The exchange in progress keeps its byte and its length, and no second exchange follows it.
- R4: The chip-select pin takes the value of control bit 1 one cycle after a control write.
- R5: Each serial-clock half period lasts max(floor(D/2), 1) system clocks, where D is control bits 31:2. A whole exchange therefore keeps busy set for exactly 16 half periods. D = 0 and D = 1 both give one clock per half period.
- R6: An exchange has exactly 8 serial-clock pulses. The serial clock is low while idle, and the output presents the transmit byte MSB first, stable at every rising edge.
- R7: The input is sampled on each rising serial-clock edge, MSB first. After the exchange, reading the data word (offset 8) returns the received byte in bits 7:0 and zero above.
- R8: A write takes effect only on a rising clock edge with device select and write enable both high and the address equal to a mapped word. Any other access leaves the control and data words unchanged.
- R9: The status word is at base+0, the control word at base+4 and the data word at base+8. Reading the control word returns the divider in bits 31:2, the chip-select level in bit 1 and 0 in bit 0. Writing 1 to control bit 0 requests a start.
- R10: Read data is 0 whenever device select is low or write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Device select |
| bus_we | input | 1 | Write enable |
| bus_addr | input | 32 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed word |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip-select level as set by software |

## Verification
Read data is combinational, so the bench samples it in the same cycle it sets the address, halfway between edges. Register writes show on the pins and in read-back one cycle after the capturing edge. After the start edge, the first serial-clock rise is due H clocks later and busy falls exactly 16·H clocks later, where H = max(floor(D/2),1). The bench timestamps the start edge, polls status once per cycle and compares the measured busy span with 16·H. A monitor timestamps every serial-clock transition at the falling system-clock edge, checks each gap against H and compares the captured output byte with the byte the driver queued.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    // Word offsets within the register window
    localparam logic [3:0] OFS_STATUS = 4'h0;
    localparam logic [3:0] OFS_CTRL   = 4'h4;
    localparam logic [3:0] OFS_DATA   = 4'h8;

    // Control word bit positions
    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_CS_BIT  = 1;
    localparam int CTRL_DIV_LSB = 2;

    // Status word bit positions
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_BUSY_BIT = 1;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              DATA_W    = 32,
    parameter int              FRAME_W   = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    localparam int             DIV_W     = DATA_W - CTRL_DIV_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               busy_i,
    input  logic               done_i,
    input  logic [FRAME_W-1:0] rx_byte_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [DIV_W-1:0]   div_o,
    output logic               cs_o,
    output logic [FRAME_W-1:0] tx_byte_o,
    output logic               start_o
);

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic               cs;
        logic [FRAME_W-1:0] tx;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic hit_status, hit_ctrl, hit_data;
    logic wr_en, rd_en;

    always_comb begin
        hit_status = (addr_i == BASE_ADDR + ADDR_W'(OFS_STATUS));
        hit_ctrl   = (addr_i == BASE_ADDR + ADDR_W'(OFS_CTRL));
        hit_data   = (addr_i == BASE_ADDR + ADDR_W'(OFS_DATA));
        wr_en      = sel_i && we_i;
        rd_en      = sel_i && !we_i;

        st_d    = st_q;
        start_o = 1'b0;
        if (wr_en && hit_ctrl) begin
            st_d.div = wdata_i[DATA_W-1:CTRL_DIV_LSB];
            st_d.cs  = wdata_i[CTRL_CS_BIT];
            start_o  = wdata_i[CTRL_GO_BIT];
        end
        if (wr_en && hit_data) begin
            st_d.tx = wdata_i[FRAME_W-1:0];
        end

        rdata_o = '0;
        if (rd_en) begin
            if (hit_status) begin
                rdata_o[STAT_DONE_BIT] = done_i;
                rdata_o[STAT_BUSY_BIT] = busy_i;
            end else if (hit_ctrl) begin
                rdata_o = {st_q.div, st_q.cs, 1'b0};
            end else if (hit_data) begin
                rdata_o[FRAME_W-1:0] = rx_byte_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o     = st_q.div;
    assign cs_o      = st_q.cs;
    assign tx_byte_o = st_q.tx;

    // R4
    cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && we_i && hit_ctrl) |=> (cs_o == $past(wdata_i[CTRL_CS_BIT])));

    // R8
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && we_i) |=> ($stable(div_o) && $stable(cs_o) && $stable(tx_byte_o)));

    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && !we_i) |-> (rdata_o == '0));

endmodule

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen #(
    parameter int DIV_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             run_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic [DIV_W-1:0] half_w;

    always_comb begin
        half_w = div_i >> 1;
        if (half_w == '0) begin
            half_w = DIV_W'(1);
        end
        tick_o = run_i && (st_q.cnt >= half_w - DIV_W'(1));

        st_d = st_q;
        if (!run_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || half_w == DIV_W'(1)));

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
    import spi_host_pkg::*;
#(
    parameter int FRAME_W = 8,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FRAME_W-1:0] tx_byte_i,
    input  logic               tick_i,
    input  logic               miso_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic [FRAME_W-1:0] rx_byte_o
);

    typedef struct packed {
        eng_state_e         state;
        logic               sclk;
        logic [CNT_W-1:0]   bits;
        logic [FRAME_W-1:0] tx_sh;
        logic [FRAME_W-1:0] rx_sh;
        logic [FRAME_W-1:0] rx_byte;
        logic               done;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ENG_IDLE: begin
                if (start_i) begin
                    st_d.state = ENG_RUN;
                    st_d.done  = 1'b0;
                    st_d.sclk  = 1'b0;
                    st_d.bits  = '0;
                    st_d.tx_sh = tx_byte_i;
                end
            end
            ENG_RUN: begin
                if (tick_i) begin
                    if (!st_q.sclk) begin
                        st_d.sclk  = 1'b1;
                        st_d.rx_sh = {st_q.rx_sh[FRAME_W-2:0], miso_i};
                    end else begin
                        st_d.sclk = 1'b0;
                        if (st_q.bits == CNT_W'(FRAME_W - 1)) begin
                            st_d.state   = ENG_IDLE;
                            st_d.done    = 1'b1;
                            st_d.rx_byte = st_q.rx_sh;
                        end else begin
                            st_d.bits  = st_q.bits + CNT_W'(1);
                            st_d.tx_sh = {st_q.tx_sh[FRAME_W-2:0], 1'b0};
                        end
                    end
                end
            end
            default: st_d.state = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ENG_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = (st_q.state == ENG_RUN);
    assign done_o    = st_q.done;
    assign sclk_o    = st_q.sclk;
    assign mosi_o    = st_q.tx_sh[FRAME_W-1];
    assign rx_byte_o = st_q.rx_byte;

    // R2
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R6
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    // R3
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !tick_i) |=> (busy_o && $stable(mosi_o)));

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                FRAME_W   = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000,
    localparam int               DIV_W     = DATA_W - CTRL_DIV_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs
);

    logic [DIV_W-1:0]   div_w;
    logic [FRAME_W-1:0] tx_byte_w;
    logic [FRAME_W-1:0] rx_byte_w;
    logic               start_w, busy_w, done_w, tick_w;

    spi_host_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .FRAME_W  (FRAME_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (bus_sel),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .busy_i   (busy_w),
        .done_i   (done_w),
        .rx_byte_i(rx_byte_w),
        .rdata_o  (bus_rdata),
        .div_o    (div_w),
        .cs_o     (spi_cs),
        .tx_byte_o(tx_byte_w),
        .start_o  (start_w)
    );

    spi_host_clkgen #(
        .DIV_W(DIV_W)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .div_i (div_w),
        .run_i (busy_w),
        .tick_o(tick_w)
    );

    spi_host_engine #(
        .FRAME_W(FRAME_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .tx_byte_i(tx_byte_w),
        .tick_i   (tick_w),
        .miso_i   (spi_miso),
        .busy_o   (busy_w),
        .done_o   (done_w),
        .sclk_o   (spi_sclk),
        .mosi_o   (spi_mosi),
        .rx_byte_o(rx_byte_w)
    );

endmodule

// File: tb/spi_host_ctrl_tb.sv
module spi_host_ctrl_tb;

    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam logic [31:0] A_STAT = BASE + 32'h0;
    localparam logic [31:0] A_CTRL = BASE + 32'h4;
    localparam logic [31:0] A_DATA = BASE + 32'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_cs;
    logic        spi_miso = 1'b0;

    spi_host_ctrl #(.BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs(spi_cs)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [7:0] mosi_byte;
        int         half;
    } exp_t;
    exp_t sb_q[$];

    logic [7:0] slave_sh = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: times serial-clock transitions and collects output bits
    initial begin
        logic prev = 1'b0;
        int   edges = 0;
        int   last_cyc = 0;
        bit   gap_ok = 1'b1;
        int   bad_gap = 0;
        int   exp_half = 1;
        logic [7:0] got = '0;
        forever begin
            @(negedge clk);
            if (rst_n && spi_sclk !== prev) begin
                if (edges == 0) begin
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R3 unexpected exchange", 1, 0);
                        exp_half = 1;
                    end else begin
                        exp_half = sb_q[0].half;
                    end
                    gap_ok = 1'b1;
                end else if (cyc - last_cyc != exp_half) begin
                    gap_ok = 1'b0;
                    bad_gap = cyc - last_cyc;
                end
                last_cyc = cyc;
                edges++;
                if (spi_sclk) begin
                    got = {got[6:0], spi_mosi};
                end else begin
                    slave_sh = {slave_sh[6:0], 1'b0};
                    spi_miso = slave_sh[7];
                end
                if (edges == 16) begin
                    // R5 half-period spacing, R6 MSB-first output byte
                    check(gap_ok, "R5 half period", bad_gap, exp_half);
                    if (sb_q.size() != 0) begin
                        check(got == sb_q[0].mosi_byte, "R6 output byte",
                              got, sb_q[0].mosi_byte);
                        void'(sb_q.pop_front());
                    end
                    edges = 0;
                end
            end
            prev = spi_sclk;
        end
    end

    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] slv,
                            input logic [29:0] div, input bit poke);
        logic [31:0] v;
        exp_t e;
        int   t0, first, half;
        bit   busy;
        half = (div >> 1) == 0 ? 1 : int'(div >> 1);
        bus_write(A_DATA, {24'h0, tx});
        slave_sh = slv;
        spi_miso = slv[7];
        e.mosi_byte = tx;
        e.half = half;
        sb_q.push_back(e);
        bus_write(A_CTRL, {div, 1'b0, 1'b1});
        t0 = cyc;
        first = 1;
        busy = 1'b1;
        while (busy) begin
            bus_read(A_STAT, v);
            if (first == 1) begin
                // R2 busy set, finished cleared on accepted start
                check(v == 32'h2, "R2 status after start", v, 2);
                first = 0;
            end
            busy = v[1];
            if (!busy) begin
                // R5 busy spans exactly 16 half periods (R3: not extended)
                check(cyc - 1 - t0 == 16 * half, "R5 busy span", cyc - 1 - t0, 16 * half);
                check(v == 32'h1, "R2 status at end", v, 1);
            end else if (poke && cyc - t0 == 3) begin
                // R3 start and new data while busy
                bus_write(A_CTRL, {div, 1'b0, 1'b1});
                bus_write(A_DATA, {24'h0, ~tx});
            end
        end
        if (!poke) begin
            bus_read(A_DATA, v);
            check(v == {24'h0, slv}, "R7 received byte", v, {24'h0, slv});
        end
        repeat (20) @(negedge clk);
        bus_read(A_STAT, v);
        check(v == 32'h1 && spi_sclk == 1'b0, "R3 no follow-on exchange", v, 1);
        check(sb_q.size() == 0, "R6 scoreboard drained", sb_q.size(), 0);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_STAT, v); check(v == 0, "R1 status", v, 0);
        bus_read(A_CTRL, v); check(v == 0, "R1 control", v, 0);
        bus_read(A_DATA, v); check(v == 0, "R1 data", v, 0);
        check({spi_sclk, spi_mosi, spi_cs} == 3'b000, "R1 pins",
              {spi_sclk, spi_mosi, spi_cs}, 0);

        // R9 control read-back layout, R4 chip-select pin
        bus_write(A_CTRL, {30'd5, 1'b1, 1'b0});
        check(spi_cs == 1'b1, "R4 cs high", spi_cs, 1);
        bus_read(A_CTRL, v);
        check(v == {30'd5, 2'b10}, "R9 control readback", v, {30'd5, 2'b10});

        // R8 writes without select, without enable, or to an unmapped word
        bus_sel = 1'b0; bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'hFFFF_FFFC;
        @(posedge clk); #1; bus_we = 1'b0; @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_CTRL; bus_wdata = 32'hFFFF_FFFC;
        @(posedge clk); #1; bus_sel = 1'b0; @(negedge clk);
        bus_write(BASE + 32'hC, 32'hFFFF_FFFC);
        bus_read(A_CTRL, v);
        check(v == {30'd5, 2'b10}, "R8 control unchanged", v, {30'd5, 2'b10});
        check(spi_cs == 1'b1, "R8 cs unchanged", spi_cs, 1);

        // R10 no select gives zero read data
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = A_CTRL;
        #1 check(bus_rdata == 0, "R10 idle read", bus_rdata, 0);
        @(negedge clk);

        bus_write(A_CTRL, 32'h0);
        check(spi_cs == 1'b0, "R4 cs low", spi_cs, 0);

        // R5 R6 R7 exchanges at several rates and patterns
        run_xfer(8'hA5, 8'h3C, 30'd0, 1'b0);
        run_xfer(8'hFF, 8'h00, 30'd1, 1'b0);
        run_xfer(8'h01, 8'h80, 30'd6, 1'b0);
        run_xfer(8'h96, 8'h69, 30'd7, 1'b0);
        // R3 start request while busy
        run_xfer(8'hC3, 8'h5A, 30'd4, 1'b1);
        bus_read(A_DATA, v);
        check(v == 32'h5A, "R7 rx after ignored start", v, 32'h5A);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule